// File: doc/BRIEF.md
# Interval Timer Counter Channel

This block is one channel of a programmable interval timer. It holds a 16-bit down-counter and a stored period. The host loads both through a byte-wide write port, low byte first. A separate tick input, one clock wide and derived from a fixed time base of about 1.19 MHz, advances the count. The channel's output pin follows the selected counting mode.

A control decoder outside the block presents the mode, the access format and the number-encoding request together with a strobe. This channel accepts only a two-byte access format with binary counting, in one of three modes: a one-time terminal-count flag, a rate generator or a square wave. Any other request raises a one-cycle error flag and changes nothing.

The host reads the count back one byte at a time, low byte first, through a registered read port. A latch strobe takes a snapshot of the count. The snapshot is served to the host until its high byte has been read.

Top module: `pit_channel`

## Requirements
- R1: Data writes alternate between low byte and high byte, starting with the low byte. Writing the low byte replaces count bits 7:0, halts counting and drives `out_pin` low.
- R2: Writing the high byte replaces count bits 15:8 and stores the full 16-bit value as the period. Counting resumes only when that value is nonzero; a zero load leaves the channel idle. In rate and square modes a nonzero load drives `out_pin` high; in terminal-count mode it stays low.
- R3: A latch strobe with no snapshot pending copies the count into a hold register and points the read sequence at the low byte. A latch strobe while a snapshot is pending has no effect.
- R4: While a snapshot is pending, reads return its low byte and then its high byte. The high-byte read releases the snapshot.
- R5: With no snapshot pending, reads return the live count, low byte then high byte, alternating on every read. `rd_data` is updated one cycle after `rd_en` and holds its value otherwise.
- R6: Mode code 0 (terminal count): each tick decrements the count. The tick that reaches zero drives `out_pin` high and halts counting. The output then stays high until a new load or control word.
- R7: Mode code 2 (rate generator): a tick at count 1 reloads the period and drives `out_pin` low for one tick interval. Every other tick decrements the count by one with `out_pin` high.
- R8: Mode code 3 (square wave): each tick subtracts 2. A tick at a count of 2 or less reloads the period and inverts `out_pin`, so the output changes level every half period.
- R9: A control word is accepted only when the format code is 3 (both bytes), the encoding bit is 0 and the mode code is 0, 2 or 3. An accepted word halts counting, drives `out_pin` low and returns both byte pointers to low. A rejected word pulses `cfg_err` high on the following cycle and leaves mode, count and output unchanged.
- R10: The count changes only on a data write or on a `tick_en` pulse while counting.
- R11: Synchronous reset clears the count, the period, the snapshot, both byte pointers, `rd_data`, `cfg_err` and `out_pin`. It selects terminal-count mode and leaves the channel idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle count-enable pulse from the time base |
| cfg_wr | input | 1 | Control word strobe |
| cfg_fmt | input | 2 | Access format code (3 = low then high) |
| cfg_mode | input | 3 | Counting mode code |
| cfg_bcd | input | 1 | Decimal counting request (must be 0) |
| wr_en | input | 1 | Data byte write strobe |
| wr_data | input | 8 | Data byte to load |
| latch_cmd | input | 1 | Snapshot request |
| rd_en | input | 1 | Data byte read strobe |
| rd_data | output | 8 | Registered read byte |
| out_pin | output | 1 | Channel output |
| cfg_err | output | 1 | One-cycle flag for an unsupported control word |

## Verification
The properties assume that the control decoder never issues a control strobe, a data write, a latch or a read in the same cycle as one another. Where the properties reason about loads and reads, they take a control strobe to outrank a data write. The stimulus applies one strobe per cycle and drives each on the falling clock edge. Ticks arrive only in cycles with no other strobe, so no ordering between simultaneous events is ever exercised. The rate-mode property also assumes a period above 1, and the stimulus uses only such periods in that mode.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [2:0] {
    MODE_TC      = 3'd0,
    MODE_ONESHOT = 3'd1,
    MODE_RATE    = 3'd2,
    MODE_SQUARE  = 3'd3
  } pit_mode_e;

  localparam logic [1:0] FMT_PAIR = 2'b11;
endpackage

// File: rtl/pit_byte_ptr.sv
// Byte pointer that walks the bytes of a multi-byte word, low byte first.
module pit_byte_ptr #(
  parameter int NBYTES = 2,
  localparam int PW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(NBYTES - 1);

  always_ff @(posedge clk) begin
    if (rst || clear)  ptr <= '0;
    else if (step)     ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/pit_ctrl_decode.sv
// Validates control words and holds the accepted counting mode.
module pit_ctrl_decode
  import pit_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cfg_wr,
  input  logic [1:0] cfg_fmt,
  input  logic [2:0] cfg_mode,
  input  logic      cfg_bcd,
  output pit_mode_e mode_q,
  output logic      cfg_apply,
  output logic      cfg_err
);
  logic mode_ok, cfg_ok;

  always_comb begin
    mode_ok = (cfg_mode == MODE_TC) || (cfg_mode == MODE_RATE) ||
              (cfg_mode == MODE_SQUARE);
    cfg_ok    = mode_ok && (cfg_fmt == FMT_PAIR) && !cfg_bcd;
    cfg_apply = cfg_wr && cfg_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_TC;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= cfg_wr && !cfg_ok;
      if (cfg_apply) mode_q <= pit_mode_e'(cfg_mode);
    end
  end
endmodule

// File: rtl/pit_count_core.sv
// Down-counter, stored period and output waveform.
module pit_count_core
  import pit_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NB = CNT_W / BYTE_W,
  localparam int PW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  pit_mode_e         mode,
  input  logic              cfg_apply,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [PW-1:0]     wptr,
  output logic [CNT_W-1:0]  count,
  output logic              running,
  output logic              out_pin
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] load_val;
  logic             first_byte, last_byte;

  always_comb begin
    load_val = count;
    load_val[wptr*BYTE_W +: BYTE_W] = wr_data;
    first_byte = (wptr == '0);
    last_byte  = (wptr == PW'(NB - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      period  <= '0;
      running <= 1'b0;
      out_pin <= 1'b0;
    end else if (cfg_apply) begin
      running <= 1'b0;
      out_pin <= 1'b0;
    end else if (wr_en) begin
      count <= load_val;
      if (first_byte) begin
        running <= 1'b0;
        out_pin <= 1'b0;
      end
      if (last_byte) begin
        period  <= load_val;
        running <= (load_val != '0);
        if (load_val != '0 && mode != MODE_TC) out_pin <= 1'b1;
      end
    end else if (tick_en && running) begin
      case (mode)
        MODE_TC: begin
          count <= count - ONE;
          if (count == ONE) begin
            out_pin <= 1'b1;
            running <= 1'b0;
          end
        end
        MODE_RATE: begin
          if (count == ONE) begin
            count   <= period;
            out_pin <= 1'b0;
          end else begin
            count   <= count - ONE;
            out_pin <= 1'b1;
          end
        end
        MODE_SQUARE: begin
          if (count <= TWO) begin
            count   <= period;
            out_pin <= ~out_pin;
          end else begin
            count <= count - TWO;
          end
        end
        default: running <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pit_read_port.sv
// Snapshot register and byte-serial read path.
module pit_read_port #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NB = CNT_W / BYTE_W,
  localparam int PW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_apply,
  input  logic              latch_cmd,
  input  logic              rd_en,
  input  logic [CNT_W-1:0]  count,
  output logic [BYTE_W-1:0] rd_data,
  output logic              latched,
  output logic [CNT_W-1:0]  hold,
  output logic [PW-1:0]     rptr
);
  logic latch_take, rd_last;

  assign latch_take = latch_cmd && !latched;
  assign rd_last    = (rptr == PW'(NB - 1));

  pit_byte_ptr #(.NBYTES(NB)) u_rptr (
    .clk  (clk),
    .rst  (rst),
    .clear(cfg_apply || latch_take),
    .step (rd_en),
    .ptr  (rptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      latched <= 1'b0;
      hold    <= '0;
    end else begin
      if (rd_en) begin
        rd_data <= latched ? hold[rptr*BYTE_W +: BYTE_W]
                           : count[rptr*BYTE_W +: BYTE_W];
        if (latched && rd_last) latched <= 1'b0;
      end
      if (latch_take) begin
        latched <= 1'b1;
        hold    <= count;
      end
    end
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_fmt,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_bcd,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              latch_cmd,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              out_pin,
  output logic              cfg_err
);
  localparam int NB = CNT_W / BYTE_W;
  localparam int PW = (NB > 1) ? $clog2(NB) : 1;

  pit_mode_e        mode_q;
  logic             cfg_apply;
  logic [PW-1:0]    wptr, rptr;
  logic [CNT_W-1:0] count, hold;
  logic             running, latched;

  pit_ctrl_decode u_dec (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_fmt(cfg_fmt),
    .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd), .mode_q(mode_q),
    .cfg_apply(cfg_apply), .cfg_err(cfg_err)
  );

  pit_byte_ptr #(.NBYTES(NB)) u_wptr (
    .clk(clk), .rst(rst), .clear(cfg_apply), .step(wr_en && !cfg_apply),
    .ptr(wptr)
  );

  pit_count_core #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_core (
    .clk(clk), .rst(rst), .mode(mode_q), .cfg_apply(cfg_apply),
    .tick_en(tick_en), .wr_en(wr_en), .wr_data(wr_data), .wptr(wptr),
    .count(count), .running(running), .out_pin(out_pin)
  );

  pit_read_port #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_rd (
    .clk(clk), .rst(rst), .cfg_apply(cfg_apply), .latch_cmd(latch_cmd),
    .rd_en(rd_en), .count(count), .rd_data(rd_data), .latched(latched),
    .hold(hold), .rptr(rptr)
  );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NB = CNT_W / BYTE_W,
  localparam int PW = (NB > 1) ? $clog2(NB) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              cfg_wr,
  input logic              wr_en,
  input logic [BYTE_W-1:0] wr_data,
  input logic              latch_cmd,
  input logic              rd_en,
  input logic              out_pin,
  input logic              cfg_err,
  input pit_mode_e         mode_q,
  input logic [PW-1:0]     wptr,
  input logic [PW-1:0]     rptr,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  hold,
  input logic              running,
  input logic              latched
);
  localparam logic [PW-1:0] LASTB = PW'(NB - 1);

  a_r1_low_byte_quiets: assert property (@(posedge clk) disable iff (rst)
    wr_en && !cfg_wr && wptr == '0 |=> !out_pin && !running);

  a_r2_load_starts_if_nonzero: assert property (@(posedge clk) disable iff (rst)
    wr_en && !cfg_wr && wptr == LASTB |=> running == (count != '0));

  a_r3_pending_latch_holds: assert property (@(posedge clk) disable iff (rst)
    latched && !(rd_en && rptr == LASTB) |=> latched && $stable(hold));

  a_r4_high_read_releases: assert property (@(posedge clk) disable iff (rst)
    rd_en && latched && rptr == LASTB && !latch_cmd |=> !latched);

  a_r6_tc_output_sticks: assert property (@(posedge clk) disable iff (rst)
    mode_q == MODE_TC && out_pin && !wr_en && !cfg_wr |=> out_pin);

  a_r7_rate_low_one_tick: assert property (@(posedge clk) disable iff (rst)
    mode_q == MODE_RATE && running && !out_pin && tick_en && !wr_en &&
    !cfg_wr && count != CNT_W'(1) |=> out_pin);

  a_r9_err_follows_cfg: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(cfg_wr));

  a_r10_idle_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick_en && !wr_en && !cfg_wr |=> $stable(count));
endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .cfg_wr(cfg_wr), .wr_en(wr_en),
  .wr_data(wr_data), .latch_cmd(latch_cmd), .rd_en(rd_en), .out_pin(out_pin),
  .cfg_err(cfg_err), .mode_q(mode_q), .wptr(wptr), .rptr(rptr), .count(count),
  .hold(hold), .running(running), .latched(latched)
);

// File: tb/sim_pit_channel.sv
module sim_pit_channel;
  localparam logic [3:0] OP_CFG = 4'd0, OP_WR = 4'd1, OP_RD = 4'd2,
                         OP_LATCH = 4'd3, OP_TICK = 4'd4, OP_OUT = 4'd5;
  localparam int NVEC = 63;

  // {op, requirement number, argument, expected}
  localparam logic [23:0] VEC [0:NVEC-1] = '{
    // terminal-count mode, load 5 (R1 R2 R5 R6)
    {OP_CFG,4'd9,8'h30,8'h00}, {OP_WR,4'd1,8'h05,8'h00}, {OP_WR,4'd2,8'h00,8'h00},
    {OP_OUT,4'd2,8'h00,8'h00}, {OP_TICK,4'd6,8'd3,8'h00}, {OP_RD,4'd5,8'h00,8'h02},
    {OP_RD,4'd5,8'h00,8'h00}, {OP_TICK,4'd6,8'd1,8'h00}, {OP_OUT,4'd6,8'h00,8'h00},
    {OP_TICK,4'd6,8'd1,8'h00}, {OP_OUT,4'd6,8'h00,8'h01}, {OP_TICK,4'd6,8'd2,8'h00},
    {OP_RD,4'd6,8'h00,8'h00}, {OP_RD,4'd6,8'h00,8'h00},
    // snapshot handling (R1 R3 R4 R5)
    {OP_WR,4'd1,8'h34,8'h00}, {OP_OUT,4'd1,8'h00,8'h00}, {OP_WR,4'd2,8'h12,8'h00},
    {OP_LATCH,4'd3,8'h00,8'h00}, {OP_TICK,4'd10,8'd4,8'h00}, {OP_LATCH,4'd3,8'h00,8'h00},
    {OP_RD,4'd4,8'h00,8'h34}, {OP_TICK,4'd10,8'd1,8'h00}, {OP_RD,4'd3,8'h00,8'h12},
    {OP_RD,4'd5,8'h00,8'h2F}, {OP_RD,4'd5,8'h00,8'h12},
    // rate generator, period 3 (R7)
    {OP_CFG,4'd9,8'h34,8'h00}, {OP_WR,4'd1,8'h03,8'h00}, {OP_WR,4'd2,8'h00,8'h00},
    {OP_OUT,4'd2,8'h00,8'h01}, {OP_TICK,4'd7,8'd2,8'h00}, {OP_OUT,4'd7,8'h00,8'h01},
    {OP_TICK,4'd7,8'd1,8'h00}, {OP_OUT,4'd7,8'h00,8'h00}, {OP_RD,4'd7,8'h00,8'h03},
    {OP_RD,4'd7,8'h00,8'h00}, {OP_TICK,4'd7,8'd1,8'h00}, {OP_OUT,4'd7,8'h00,8'h01},
    // square wave, period 4 (R8)
    {OP_CFG,4'd9,8'h36,8'h00}, {OP_WR,4'd1,8'h04,8'h00}, {OP_WR,4'd2,8'h00,8'h00},
    {OP_TICK,4'd8,8'd1,8'h00}, {OP_OUT,4'd8,8'h00,8'h01}, {OP_RD,4'd8,8'h00,8'h02},
    {OP_RD,4'd8,8'h00,8'h00}, {OP_TICK,4'd8,8'd1,8'h00}, {OP_OUT,4'd8,8'h00,8'h00},
    {OP_TICK,4'd8,8'd1,8'h00}, {OP_TICK,4'd8,8'd1,8'h00}, {OP_OUT,4'd8,8'h00,8'h01},
    // rejected control words leave square wave running (R9)
    {OP_CFG,4'd9,8'h10,8'h01}, {OP_CFG,4'd9,8'h31,8'h01}, {OP_CFG,4'd9,8'h32,8'h01},
    {OP_TICK,4'd9,8'd1,8'h00}, {OP_OUT,4'd9,8'h00,8'h01}, {OP_RD,4'd9,8'h00,8'h02},
    {OP_RD,4'd9,8'h00,8'h00},
    // zero load stays idle (R2 R10)
    {OP_CFG,4'd9,8'h30,8'h00}, {OP_WR,4'd1,8'h00,8'h00}, {OP_WR,4'd2,8'h00,8'h00},
    {OP_TICK,4'd10,8'd3,8'h00}, {OP_RD,4'd2,8'h00,8'h00}, {OP_RD,4'd2,8'h00,8'h00},
    {OP_OUT,4'd2,8'h00,8'h00}
  };

  logic       clk = 1'b0, rst = 1'b1;
  logic       tick_en = 1'b0, cfg_wr = 1'b0, cfg_bcd = 1'b0;
  logic [1:0] cfg_fmt = '0;
  logic [2:0] cfg_mode = '0;
  logic       wr_en = 1'b0, latch_cmd = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       out_pin, cfg_err;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pit_channel u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cfg_wr(cfg_wr), .cfg_fmt(cfg_fmt),
    .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd), .wr_en(wr_en), .wr_data(wr_data),
    .latch_cmd(latch_cmd), .rd_en(rd_en), .rd_data(rd_data), .out_pin(out_pin),
    .cfg_err(cfg_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; leaves at the next falling edge.
  task automatic do_op(input logic [3:0] op, input logic [3:0] req,
                       input logic [7:0] a, input logic [7:0] e);
    string tag;
    tag = $sformatf("R%0d", req);
    case (op)
      OP_CFG: begin
        cfg_wr = 1'b1; cfg_fmt = a[5:4]; cfg_mode = a[3:1]; cfg_bcd = a[0];
        @(negedge clk); cfg_wr = 1'b0;
        check(tag, int'(cfg_err), int'(e[0]));
      end
      OP_WR: begin
        wr_en = 1'b1; wr_data = a; @(negedge clk); wr_en = 1'b0;
      end
      OP_RD: begin
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        check(tag, int'(rd_data), int'(e));
      end
      OP_LATCH: begin
        latch_cmd = 1'b1; @(negedge clk); latch_cmd = 1'b0;
      end
      OP_TICK: begin
        for (int k = 0; k < int'(a); k++) begin
          tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
        end
      end
      default: begin
        check(tag, int'(out_pin), int'(e[0]));
        @(negedge clk);
      end
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: state after reset
    check("R11", int'(out_pin), 0);
    check("R11", int'(cfg_err), 0);
    check("R11", int'(rd_data), 0);

    for (int i = 0; i < NVEC; i++)
      do_op(VEC[i][23:20], VEC[i][19:16], VEC[i][15:8], VEC[i][7:0]);

    // R11: reset mid-load with a snapshot pending and square mode selected
    do_op(OP_CFG, 4'd11, 8'h36, 8'h00);
    do_op(OP_WR, 4'd11, 8'h09, 8'h00);
    do_op(OP_LATCH, 4'd11, 8'h00, 8'h00);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R11", int'(out_pin), 0);
    check("R11", int'(rd_data), 0);
    do_op(OP_RD, 4'd11, 8'h00, 8'h00);
    do_op(OP_RD, 4'd11, 8'h00, 8'h00);
    do_op(OP_WR, 4'd11, 8'h07, 8'h00);
    do_op(OP_WR, 4'd11, 8'h00, 8'h00);
    do_op(OP_OUT, 4'd11, 8'h00, 8'h00);
    do_op(OP_RD, 4'd11, 8'h00, 8'h07);
    do_op(OP_RD, 4'd11, 8'h00, 8'h00);
    do_op(OP_TICK, 4'd6, 8'd7, 8'h00);
    do_op(OP_OUT, 4'd11, 8'h00, 8'h01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule